// File: doc/BRIEF.md
# Isolated Logic Channel Controller

This block models one one-way logic channel that crosses a supply boundary. It runs from a single fast reference clock. On the sending side, the input pin passes through a two-flop synchroniser and a glitch filter. Each accepted level is then coded as a short pulse on a one-bit link. The sending side also resends the level it holds on a fixed refresh timer, so a receiver that missed a pulse, or that has just powered up, still reaches the correct level.

On the receiving side, the pulse length is decoded back into a level. A small sequencer then picks one of three output modes from two undervoltage flags, one for each supply side:

- **High impedance** while the receiving supply is low.
- **Default level** (a parameter) while the sending supply is lost, or during a fixed interval after the receiving supply returns.
- **Filtered data** otherwise.

All time constants are parameters in microseconds or hertz. They are converted to clock counts using the clock rate in MHz. The two filter options are a window of about 29 ns and one of about 70 ns.

Top module: `iso_channel_ctrl`

## Requirements
- R1: The synchronised input must differ from the accepted level for GLITCH_CYC consecutive clocks before it is accepted. GLITCH_CYC is ceil(window_ns × CLK_MHZ / 1000), which at 100 MHz is 7 for the slow option and 3 for the fast option. A pulse one clock shorter than that never reaches `dout`.
- R2: With the slow filter, a 100 ns pulse reaches `dout`. A train of 10-clock-high / 10-clock-low pulses (10 Mb/s at 100 MHz) reproduces every pulse at `dout`.
- R3: While `out_uv` is high, `dout_oe` is low in the same cycle, whatever `din`, `in_uv` or the link do.
- R4: While `in_uv` is high and `out_uv` is low, `dout` keeps its last data for PWRDN_CYC = PWRDN_US × CLK_MHZ clocks. After that it drives the default level, and `din` has no effect.
- R5: With both flags low and the power-up interval over, `dout` follows the filtered input: high gives 1 and low gives 0.
- R6: After `out_uv` falls, `dout_oe` rises one clock later with `dout` at the default level. `dout` stays at the default level for PWRUP_CYC = PWRUP_US × CLK_MHZ clocks, and only after that shows data.
- R7: While `in_uv` is low, a link symbol starts at least once every REFRESH_CYC = CLK_MHZ×10^6 / REFRESH_HZ clocks, even with a static input. A symbol lost on the link is therefore corrected within one refresh period.
- R8: Link coding: a single-clock high pulse on `link_tx` means level 0. A two-clock high pulse means level 1. Every pulse is followed by at least one low clock. `link_tx` is low while `in_uv` is high.
- R9: During reset, `dout_oe` and `link_tx` are low.
- R10: When `in_uv` falls again after a loss, `dout` shows the default level until a fresh symbol arrives. The sending side sends that symbol without waiting for the refresh timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_uv | input | 1 | Sending-side supply undervoltage flag |
| out_uv | input | 1 | Receiving-side supply undervoltage flag |
| din | input | 1 | Input pin, asynchronous |
| link_tx | output | 1 | Coded pulse stream toward the far side |
| link_rx | input | 1 | Coded pulse stream arriving at the receiver |
| dout | output | 1 | Output data level |
| dout_oe | output | 1 | Output drive enable; low means high impedance |

## Verification
The assertions assume three things about the inputs:

- The two supply flags are clean synchronous levels.
- `link_rx` is a copy of `link_tx` that may lose whole pulses but never cuts one short or lengthens it.
- The refresh bound applies only when the sending side has been up long enough to send.

The stimulus stays within these limits. It changes flags and `din` only at the falling clock edge. It blocks the link only while `link_tx` is low, and it releases the link only while `link_tx` is low, so every pulse is either delivered whole or lost whole.

// File: rtl/iso_channel_ctrl.sv
module iso_channel_ctrl #(
  parameter int CLK_MHZ     = 100,
  parameter bit SLOW_FILTER = 1'b1,
  parameter bit DEF_LVL     = 1'b0,
  parameter int REFRESH_HZ  = 10_000,
  parameter int PWRUP_US    = 1100,
  parameter int PWRDN_US    = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_uv,
  input  logic out_uv,
  input  logic din,
  output logic link_tx,
  input  logic link_rx,
  output logic dout,
  output logic dout_oe
);
  localparam int GLITCH_NS   = SLOW_FILTER ? 70 : 29;
  localparam int GLITCH_CYC  = (GLITCH_NS * CLK_MHZ + 999) / 1000;
  localparam int REFRESH_CYC = (CLK_MHZ * 1_000_000) / REFRESH_HZ;
  localparam int PWRUP_CYC   = PWRUP_US * CLK_MHZ;
  localparam int PWRDN_CYC   = PWRDN_US * CLK_MHZ;
  localparam int GW = $clog2(GLITCH_CYC + 1);
  localparam int RW = $clog2(REFRESH_CYC + 1);
  localparam int UW = $clog2(PWRUP_CYC + 1);
  localparam int DW = $clog2(PWRDN_CYC + 1);

  typedef enum logic [1:0] {OS_HIZ, OS_WAIT, OS_RUN} ostate_t;

  // sending side
  logic [1:0]    sync;
  logic          filt, sent, need_send;
  logic [GW-1:0] gcnt;
  logic [2:0]    tx_sh;
  logic [RW-1:0] rcnt;

  wire in_rst  = !rst_n || in_uv;
  wire rf_due  = rcnt >= RW'(REFRESH_CYC - 1);
  wire tx_go   = (tx_sh == 3'd0) && (need_send || (filt != sent) || rf_due);

  always_ff @(posedge clk) begin
    if (in_rst) begin
      sync      <= {2{DEF_LVL}};
      filt      <= DEF_LVL;
      gcnt      <= '0;
      sent      <= DEF_LVL;
      need_send <= 1'b1;
      tx_sh     <= '0;
      rcnt      <= '0;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == filt)
        gcnt <= '0;
      else if (gcnt == GW'(GLITCH_CYC - 1)) begin
        filt <= sync[1];
        gcnt <= '0;
      end else
        gcnt <= gcnt + 1'b1;

      if (tx_go) begin
        tx_sh     <= filt ? 3'b011 : 3'b001;
        sent      <= filt;
        need_send <= 1'b0;
        rcnt      <= '0;
      end else begin
        tx_sh <= tx_sh >> 1;
        if (!rf_due) rcnt <= rcnt + 1'b1;
      end
    end
  end

  assign link_tx = tx_sh[0];

  // sending-side loss timer
  logic [DW-1:0] dcnt;
  wire in_lost = (dcnt == DW'(PWRDN_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n || !in_uv) dcnt <= '0;
    else if (!in_lost)    dcnt <= dcnt + 1'b1;
  end

  // receiving side
  ostate_t       st;
  logic [UW-1:0] ucnt;
  logic [1:0]    rx_len;
  logic          rx_data, rx_valid;

  always_ff @(posedge clk) begin
    if (!rst_n || out_uv) begin
      st       <= OS_HIZ;
      ucnt     <= '0;
      rx_len   <= '0;
      rx_data  <= DEF_LVL;
      rx_valid <= 1'b0;
    end else begin
      case (st)
        OS_HIZ:  begin st <= OS_WAIT; ucnt <= '0; end
        OS_WAIT: if (ucnt == UW'(PWRUP_CYC - 1)) st <= OS_RUN;
                 else ucnt <= ucnt + 1'b1;
        default: st <= OS_RUN;
      endcase

      if (link_rx) begin
        if (rx_len != 2'd2) rx_len <= rx_len + 1'b1;
      end else if (rx_len != 2'd0) begin
        rx_data  <= (rx_len == 2'd2);
        rx_valid <= 1'b1;
        rx_len   <= '0;
      end

      if (in_lost) begin
        rx_valid <= 1'b0;
        rx_len   <= '0;
      end
    end
  end

  assign dout_oe = !out_uv && (st != OS_HIZ);
  assign dout    = (st == OS_RUN && rx_valid && !in_lost) ? rx_data : DEF_LVL;
endmodule

// File: rtl/iso_channel_ctrl_chk.sv
module iso_channel_ctrl_chk #(
  parameter bit DEF_LVL     = 1'b0,
  parameter int REFRESH_CYC = 10_000,
  parameter int PWRDN_CYC   = 50_000
) (
  input logic clk,
  input logic rst_n,
  input logic in_uv,
  input logic out_uv,
  input logic link_tx,
  input logic dout,
  input logic dout_oe
);
  int   uv_cnt;
  int   rf_cnt;
  logic link_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_uv) uv_cnt <= 0;
    else if (uv_cnt <= PWRDN_CYC) uv_cnt <= uv_cnt + 1;

    link_q <= rst_n ? link_tx : 1'b0;
    if (!rst_n || in_uv || (link_tx && !link_q)) rf_cnt <= 0;
    else if (rf_cnt <= REFRESH_CYC + 4) rf_cnt <= rf_cnt + 1;
  end

  p_hiz_on_out_uv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_uv |-> !dout_oe);

  p_default_in_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_uv && uv_cnt >= PWRDN_CYC && dout_oe) |-> (dout == DEF_LVL));

  p_oe_rise_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> (dout == DEF_LVL));

  p_refresh_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_uv |-> (rf_cnt <= REFRESH_CYC + 2));

  p_pulse_max_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_tx && $past(link_tx)) |=> !link_tx);

  p_link_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_uv |=> !link_tx);
endmodule

bind iso_channel_ctrl iso_channel_ctrl_chk #(
  .DEF_LVL(DEF_LVL), .REFRESH_CYC(REFRESH_CYC), .PWRDN_CYC(PWRDN_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_uv(in_uv), .out_uv(out_uv),
  .link_tx(link_tx), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/iso_channel_ctrl_tb_top.sv
module iso_channel_ctrl_tb_top;
  localparam int  CLK_MHZ     = 100;
  localparam bit  DEF         = 1'b1;
  localparam int  REFRESH_HZ  = 100_000;
  localparam int  PWRUP_US    = 20;
  localparam int  PWRDN_US    = 10;
  localparam int  REFRESH_CYC = CLK_MHZ * 1_000_000 / REFRESH_HZ;
  localparam int  PWRUP_CYC   = PWRUP_US * CLK_MHZ;
  localparam int  PWRDN_CYC   = PWRDN_US * CLK_MHZ;
  localparam int  GLITCH_CYC  = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_uv, out_uv, din, drop;
  logic link_tx, dout, dout_oe;
  wire  link_rx = link_tx & ~drop;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  iso_channel_ctrl #(
    .CLK_MHZ(CLK_MHZ), .SLOW_FILTER(1'b1), .DEF_LVL(DEF),
    .REFRESH_HZ(REFRESH_HZ), .PWRUP_US(PWRUP_US), .PWRDN_US(PWRDN_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_uv(in_uv), .out_uv(out_uv), .din(din),
    .link_tx(link_tx), .link_rx(link_rx), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_link_low();
    while (link_tx) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 0; in_uv = 1; out_uv = 1; din = 0; drop = 0;
    cyc(3);
    chk("R9", "oe in reset", dout_oe, 0);
    chk("R9", "link in reset", link_tx, 0);
    rst_n = 1;
    cyc(2);
    chk("R3", "oe with out_uv", dout_oe, 0);
  endtask

  task automatic t_powerup();
    din = 0; in_uv = 0; out_uv = 0;
    cyc(2);
    chk("R6", "oe after recovery", dout_oe, 1);
    chk("R6", "default first", dout, DEF);
    cyc(PWRUP_CYC - 10);
    chk("R6", "default near end of interval", dout, DEF);
    cyc(15);
    chk("R6", "data after interval", dout, 0);
  endtask

  task automatic t_follow();
    din = 1; cyc(30);
    chk("R5", "follow high", dout, 1);
    din = 0; cyc(30);
    chk("R5", "follow low", dout, 0);
  endtask

  task automatic t_link_code(input logic lvl, input int width);
    int w = 0;
    bit seen = 0;
    din = lvl; cyc(20);
    for (int i = 0; i < REFRESH_CYC + 5 && !seen; i++) begin
      @(negedge clk);
      if (link_tx) seen = 1;
    end
    chk("R7", "refresh symbol seen", seen, 1);
    while (link_tx) begin w++; @(negedge clk); end
    chk("R8", $sformatf("pulse width for level %0d", lvl), w, width);
  endtask

  task automatic t_pulse(input int n, input bit expect_seen, input string req);
    bit seen = 0;
    din = 0; cyc(30);
    din = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (dout) seen = 1;
    end
    din = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dout) seen = 1;
    end
    chk(req, $sformatf("pulse of %0d clocks", n), seen, expect_seen);
  endtask

  task automatic t_rate();
    int rises = 0;
    logic prev;
    din = 0; cyc(30);
    prev = dout;
    for (int p = 0; p < 8; p++) begin
      din = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (dout && !prev) rises++;
        prev = dout;
      end
      din = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (dout && !prev) rises++;
        prev = dout;
      end
    end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (dout && !prev) rises++;
      prev = dout;
    end
    chk("R2", "pulses at 10 Mb/s", rises, 8);
  endtask

  task automatic t_missed();
    bit fixed = 0;
    din = 0; cyc(30);
    wait_link_low();
    drop = 1; din = 1;
    cyc(30);
    wait_link_low();
    drop = 0;
    cyc(1);
    chk("R7", "edge lost on link", dout, 0);
    for (int i = 0; i < REFRESH_CYC + 20 && !fixed; i++) begin
      @(negedge clk);
      if (dout) fixed = 1;
    end
    chk("R7", "refresh repairs lost edge", fixed, 1);
  endtask

  task automatic t_in_loss();
    din = 0; cyc(30);
    in_uv = 1;
    cyc(PWRDN_CYC - 5);
    chk("R4", "holds data before timeout", dout, 0);
    cyc(10);
    chk("R4", "default after timeout", dout, DEF);
    chk("R4", "still driving", dout_oe, 1);
    din = 1; cyc(20); din = 0; cyc(20);
    chk("R4", "din ignored", dout, DEF);
  endtask

  task automatic t_in_recover();
    din = 0;
    in_uv = 0;
    cyc(1);
    chk("R10", "default until fresh symbol", dout, DEF);
    cyc(30);
    chk("R10", "data after fresh symbol", dout, 0);
  endtask

  task automatic t_out_loss();
    @(negedge clk);
    out_uv = 1;
    #1;
    chk("R3", "oe drops at once", dout_oe, 0);
    din = 1; cyc(20); din = 0; cyc(5);
    chk("R3", "oe stays low", dout_oe, 0);
    in_uv = 1;
    cyc(PWRDN_CYC + 5);
    out_uv = 0;
    cyc(PWRUP_CYC + 20);
    chk("R4", "default with sending side down", dout, DEF);
    chk("R6", "driving after power-up", dout_oe, 1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_follow();
    t_link_code(1'b1, 2);
    t_link_code(1'b0, 1);
    t_pulse(GLITCH_CYC - 1, 1'b0, "R1");
    t_pulse(GLITCH_CYC, 1'b1, "R1");
    t_pulse(10, 1'b1, "R2");
    t_rate();
    t_missed();
    t_in_loss();
    t_in_recover();
    t_out_loss();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule